// File: doc/BRIEF.md
# Wire Mirror Bank with Toggle Interrupt

This block places a 64-bit general-purpose input bus and a 64-bit general-purpose output bus behind a small register bank that firmware reaches through a plain synchronous port. The port has a write strobe, a word address, write data and registered read data. The input bus passes through a flop synchronizer, and its settled value can be read as two 32-bit words. The output bus is held in two writable 32-bit words, so firmware alone decides what it drives.

Every synchronized input value is compared with the value one cycle earlier. A change on any bit, rising or falling, sets a sticky status flag. Firmware clears the flag by writing a one to it. The interrupt line is the flag gated by an enable bit. The flag keeps recording changes while the line is masked, so firmware can poll it.

Top module: `wire_mirror_bank`

## Requirements
- R1: While reset is asserted, and on its release, `wire_out`, `reg_rdata` and `irq_o` are all zero.
- R2: Reading word 0 returns input bits 31:0 and reading word 1 returns bits 63:32. The value read is the input as it stood two clock edges earlier (two synchronizer stages). `reg_rdata` shows the word addressed at the previous clock edge.
- R3: Writes to words 0 and 1 have no effect on what those words read back.
- R4: A write to word 2 sets `wire_out[31:0]` and a write to word 3 sets `wire_out[63:32]`, from the clock edge of the write onward. Both words read back what was written. `wire_out` changes only on such writes.
- R5: A change on any input bit, in either direction, sets the status flag (word 4, bit 0). The flag is set at the edge after the change becomes visible in words 0/1.
- R6: Writing word 4 with bit 0 = 1 clears the status flag. Writing it with bit 0 = 0 leaves the flag unchanged. If a toggle is detected in the same cycle as a clear, the flag stays set.
- R7: Word 5 bit 0 is the interrupt enable. `irq_o` is high exactly when the status flag and the enable are both 1. The flag still records toggles while the enable is 0.
- R8: No toggle is flagged after reset release while the inputs stay constant at zero. A constant nonzero input sets the flag only once.
- R9: Words 6 and 7 read zero, and the unused bits 31:1 of words 4 and 5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_in | input | 64 | General-purpose input bus |
| wire_out | output | 64 | General-purpose output bus, driven by firmware |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Toggle notification interrupt |

## Verification
The inputs are driven with the following patterns:
- A single high bit in the upper word and another in the lower word, which separates the word ordering and the half selection.
- A return to all zeros, which shows that falling edges are detected as well as rising ones.
- A long constant stretch, which shows that a held value is not flagged again.

The flag is exercised unmasked, masked, and with a clear that lands in the exact cycle of a toggle; these cases tell the set-priority rule apart from a clear-priority rule. Output words are written with distinct patterns in each half and read back, and the read-only and unmapped words are written and read to confirm they stay unaffected.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int unsigned ADDR_W = 3;

  // Word map; the bench and firmware both decode these offsets.
  typedef enum logic [ADDR_W-1:0] {
    ADR_IN_LO  = 3'd0,
    ADR_IN_HI  = 3'd1,
    ADR_OUT_LO = 3'd2,
    ADR_OUT_HI = 3'd3,
    ADR_STAT   = 3'd4,
    ADR_EN     = 3'd5
  } wmb_addr_e;
endpackage

// File: rtl/wmb_sync_edge.sv
module wmb_sync_edge #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic         toggle_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_o;
  end

  // Any bit that differs from its value one cycle earlier is a toggle.
  assign toggle_o = |(sync_o ^ prev_q);
endmodule

// File: rtl/wmb_regbank.sv
module wmb_regbank
  import wmb_pkg::*;
#(
  parameter int unsigned W = 64,
  localparam int unsigned HW = W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      sync_val,
  input  logic              toggle,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HW-1:0]     wdata,
  output logic [HW-1:0]     rdata,
  output logic [W-1:0]      out_val,
  output logic              stat_o,
  output logic              irq
);
  logic [W-1:0]  out_q, out_d;
  logic          out_en;
  logic          stat_q, stat_d;
  logic          en_q, en_d;
  logic [HW-1:0] rd_q, rd_d;

  // Next-state logic
  always_comb begin
    out_d = out_q;
    en_d  = en_q;
    stat_d = stat_q;
    out_en = 1'b0;
    if (we && addr == ADR_OUT_LO) begin
      out_d[HW-1:0] = wdata;
      out_en = 1'b1;
    end
    if (we && addr == ADR_OUT_HI) begin
      out_d[W-1:HW] = wdata;
      out_en = 1'b1;
    end
    if (we && addr == ADR_EN) en_d = wdata[0];
    if (we && addr == ADR_STAT && wdata[0]) stat_d = 1'b0;
    if (toggle) stat_d = 1'b1;     // a fresh toggle outranks a clear
  end

  always_comb begin
    case (addr)
      ADR_IN_LO:  rd_d = sync_val[HW-1:0];
      ADR_IN_HI:  rd_d = sync_val[W-1:HW];
      ADR_OUT_LO: rd_d = out_q[HW-1:0];
      ADR_OUT_HI: rd_d = out_q[W-1:HW];
      ADR_STAT:   rd_d = {{(HW-1){1'b0}}, stat_q};
      ADR_EN:     rd_d = {{(HW-1){1'b0}}, en_q};
      default:    rd_d = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      stat_q <= stat_d;
      en_q   <= en_d;
      rd_q   <= rd_d;
    end
  end

  assign out_val = out_q;
  assign rdata   = rd_q;
  assign stat_o  = stat_q;
  assign irq     = stat_q & en_q;
endmodule

// File: rtl/wire_mirror_bank.sv
module wire_mirror_bank
  import wmb_pkg::*;
#(
  parameter int unsigned WIRE_W      = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = WIRE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIRE_W-1:0] wire_in,
  output logic [WIRE_W-1:0] wire_out,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [WIRE_W-1:0] sync_val;
  logic              toggle_any;
  logic              stat_bit;

  wmb_sync_edge #(.W(WIRE_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(wire_in),
    .sync_o(sync_val), .toggle_o(toggle_any)
  );

  wmb_regbank #(.W(WIRE_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .sync_val(sync_val), .toggle(toggle_any),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .out_val(wire_out), .stat_o(stat_bit), .irq(irq_o)
  );
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker
  import wmb_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              clr_bit,
  input logic [W-1:0]      gout,
  input logic              irq,
  input logic              toggle,
  input logic              stat
);
  AST_TOGGLE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> stat);  // R5
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> $past(toggle));  // R5
  AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_STAT && clr_bit && !toggle) |=> !stat);  // R6
  AST_OUT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gout) |-> $past(we && (addr == ADR_OUT_LO || addr == ADR_OUT_HI)));  // R4
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(toggle) || $past(we && addr == ADR_EN)));  // R7
endmodule

bind wire_mirror_bank wmb_checker #(.W(WIRE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
  .clr_bit(reg_wdata[0]), .gout(wire_out), .irq(irq_o),
  .toggle(toggle_any), .stat(stat_bit)
);

// File: tb/test_wire_mirror_bank.sv
`timescale 1ns/1ps
module test_wire_mirror_bank;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wire_in = '0;
  logic [63:0] wire_out;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wire_mirror_bank i_wire_mirror_bank (
    .clk(clk), .rst_n(rst_n), .wire_in(wire_in), .wire_out(wire_out),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [63:0] m_pipe[$];
  logic [63:0] m_refl, m_refl_old, m_out;
  logic        m_stat, m_en;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = {};
      for (int i = 0; i < SYNC - 1; i++) m_pipe.push_back(64'h0);
      m_refl = '0; m_refl_old = '0; m_out = '0;
      m_stat = 1'b0; m_en = 1'b0; m_rd = '0;
    end else begin
      bit changed;
      changed = (m_refl != m_refl_old);
      case (reg_addr)
        3'd0: m_rd = m_refl[31:0];
        3'd1: m_rd = m_refl[63:32];
        3'd2: m_rd = m_out[31:0];
        3'd3: m_rd = m_out[63:32];
        3'd4: m_rd = {31'h0, m_stat};
        3'd5: m_rd = {31'h0, m_en};
        default: m_rd = '0;
      endcase
      if (reg_we) begin
        if (reg_addr == 3'd2) m_out[31:0] = reg_wdata;
        if (reg_addr == 3'd3) m_out[63:32] = reg_wdata;
        if (reg_addr == 3'd5) m_en = reg_wdata[0];
        if (reg_addr == 3'd4 && reg_wdata[0]) m_stat = 1'b0;
      end
      if (changed) m_stat = 1'b1;
      m_refl_old = m_refl;
      m_pipe.push_back(wire_in);
      m_refl = m_pipe.pop_front();
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (wire_out !== m_out) begin
        errors++;
        $display("FAIL R4 wire_out actual=%h expected=%h", wire_out, m_out);
      end
      checks++;
      if (reg_rdata !== m_rd) begin
        errors++;
        $display("FAIL R2 reg_rdata actual=%h expected=%h", reg_rdata, m_rd);
      end
      checks++;
      if (irq_o !== (m_stat & m_en)) begin
        errors++;
        $display("FAIL R7 irq_o actual=%b expected=%b", irq_o, m_stat & m_en);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag, logic [31:0] exp);
    reg_addr = a;
    tick();
    chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 reset wire_out", wire_out, '0);
    chk("R1 reset rdata", {32'h0, reg_rdata}, '0);
    chk("R1 reset irq", {63'h0, irq_o}, '0);
    rst_n = 1'b1;
    chk("R1 release irq", {63'h0, irq_o}, '0);

    repeat (6) tick();
    rd(3'd4, "R8 no flag after reset", 32'h0);

    wr(3'd5, 32'h1);
    rd(3'd5, "R7 enable readback", 32'h1);
    wire_in = 64'h0000_0001_8000_0000;
    repeat (4) tick();
    rd(3'd0, "R2 low word", 32'h8000_0000);
    rd(3'd1, "R2 high word", 32'h0000_0001);
    rd(3'd4, "R5 rising toggle flag", 32'h1);
    chk("R7 irq enabled", {63'h0, irq_o}, 64'h1);

    wr(3'd4, 32'h0);
    rd(3'd4, "R6 write zero keeps flag", 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, "R6 clear flag", 32'h0);
    chk("R6 irq after clear", {63'h0, irq_o}, '0);
    repeat (8) tick();
    rd(3'd4, "R8 constant input no reflag", 32'h0);

    wire_in = '0;
    repeat (4) tick();
    rd(3'd4, "R5 falling toggle flag", 32'h1);

    wr(3'd5, 32'h0);
    wr(3'd4, 32'h1);
    wire_in = 64'h4000_0000_0000_0000;
    repeat (4) tick();
    chk("R7 masked irq", {63'h0, irq_o}, '0);
    rd(3'd4, "R7 masked flag recorded", 32'h1);
    wr(3'd5, 32'h1);
    chk("R7 unmask raises irq", {63'h0, irq_o}, 64'h1);

    wr(3'd4, 32'h1);
    wire_in = 64'h4000_0000_0000_0002;
    repeat (SYNC) tick();
    wr(3'd4, 32'h1);  // lands in the toggle cycle
    rd(3'd4, "R6 toggle outranks clear", 32'h1);

    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, "R3 word0 unaffected", 32'h0000_0002);
    rd(3'd1, "R3 word1 unaffected", 32'h4000_0000);

    wr(3'd2, 32'hA5A5_0F0F);
    chk("R4 low half driven", wire_out, 64'h0000_0000_A5A5_0F0F);
    wr(3'd3, 32'h1234_8001);
    chk("R4 both halves", wire_out, 64'h1234_8001_A5A5_0F0F);
    rd(3'd2, "R4 low readback", 32'hA5A5_0F0F);
    rd(3'd3, "R4 high readback", 32'h1234_8001);

    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, "R9 word6 zero", 32'h0);
    rd(3'd7, "R9 word7 zero", 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, "R9 enable upper bits zero", 32'h1);
    chk("R4 unmapped write keeps outputs", wire_out, 64'h1234_8001_A5A5_0F0F);

    tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule